// File: doc/BRIEF.md
# Link Integrity Monitor

This block watches the receive side of a twisted-pair port and decides whether the link partner is alive. It takes two inputs from the receive logic: a one-cycle strobe for each qualified link pulse, and a level that is high while a valid frame is being received. From these, and from a 10 MHz timebase, it keeps a single age counter. The counter measures two limits: a short minimum spacing and a long failure limit. Only activity that falls between the two limits counts as proof of a healthy link.

The block has two outputs. The first is a link-fail flag. The second is a status line meant to drive an indicator LED. The status line is low while the link has failed. It is steady high while the link is good and only link pulses arrive. It toggles at a fixed period while a frame is being received. Once the link has failed, the block recovers in one of two ways: as soon as data is seen, or after a short chain of link pulses that are spaced correctly. Pulse detection and data qualification happen upstream and are not part of this block.

"Age" below means the number of rising clock edges since reset or since the last timer restart.

Top module: `link_integrity_mon`

## Requirements
- R1: After reset, `link_fail` is 0, `status_led` is 1 and the age is 0.
- R2: While the link is good, a `lp_strobe` at an edge where the age lies in MIN_CYC..FAIL_CYC-1 restarts the age at 0.
- R3: While the link is good, a `lp_strobe` at an edge where the age is below MIN_CYC is invalid. It does not restart the age, and the age keeps counting.
- R4: While the link is good, if no valid event restarts the age, `link_fail` rises at the edge that sees an age of FAIL_CYC-1. This is the FAIL_CYC-th edge since the last restart.
- R5: `status_led` is 0 whenever `link_fail` is 1.
- R6: While the link has failed, `data_active` high at an edge clears `link_fail` at that edge.
- R7: While the link has failed, the first `lp_strobe` starts a chain and restarts the age. Each further strobe that arrives in the window extends the chain. The link returns to good when the chain reaches RELINK_PULSES strobes. An early strobe starts a new chain of one. Reaching an age of FAIL_CYC-1 with no strobe drops the chain.
- R8: While the link is good and `data_active` is held high, `status_led` starts high and inverts once every TOG_CYC edges.
- R9: While the link is good and `data_active` is low, `status_led` is steady high.
- R10: While the link is good, `data_active` counts as a valid event inside the window. As a result, continuous data never lets the link fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 10 MHz timebase |
| rst_n | input | 1 | Active-low synchronous reset |
| lp_strobe | input | 1 | One-cycle strobe for each qualified link pulse |
| data_active | input | 1 | High while a valid frame is being received |
| link_fail | output | 1 | High while the link is in the failed state |
| status_led | output | 1 | Low on fail, high when OK, toggling while data is received |

## Verification
The assertions assume that `lp_strobe` is a single-cycle strobe from an upstream qualifier. They also assume that the parameters satisfy MIN_CYC < FAIL_CYC, so the failure edge always lies inside the window. The bench uses small timer values so that every boundary can be reached within a short run. It drives each strobe for exactly one clock and changes inputs only on falling edges. The data level is held for whole frames that are longer than several toggle periods and longer than the failure limit.

// File: rtl/link_integrity_mon.sv
module link_integrity_mon #(
  parameter int MIN_CYC       = 20000,
  parameter int FAIL_CYC      = 650000,
  parameter int TOG_CYC       = 1000000,
  parameter int RELINK_PULSES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lp_strobe,
  input  logic data_active,
  output logic link_fail,
  output logic status_led
);

  localparam int AW = $clog2(FAIL_CYC);
  localparam int TW = $clog2(TOG_CYC + 1);
  localparam int CW = $clog2(RELINK_PULSES + 1);

  logic [AW-1:0] age;
  logic [CW-1:0] chain;
  logic [TW-1:0] tog;
  logic          led_q;

  wire in_win   = age >= AW'(MIN_CYC);
  wire at_limit = age == AW'(FAIL_CYC - 1);
  wire evt      = lp_strobe | data_active;
  wire good_lp  = (chain == '0) | in_win;
  wire chain_done = chain == CW'(RELINK_PULSES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      age       <= '0;
      chain     <= '0;
      link_fail <= 1'b0;
    end else if (!link_fail) begin
      if (evt && in_win) begin
        age <= '0;
      end else if (at_limit) begin
        link_fail <= 1'b1;
        age       <= '0;
        chain     <= '0;
      end else begin
        age <= age + AW'(1);
      end
    end else begin
      if (data_active) begin
        link_fail <= 1'b0;
        age       <= '0;
        chain     <= '0;
      end else if (lp_strobe) begin
        age <= '0;
        if (good_lp) begin
          if (chain_done) begin
            link_fail <= 1'b0;
            chain     <= '0;
          end else begin
            chain <= chain + CW'(1);
          end
        end else begin
          chain <= CW'(1);
        end
      end else if (at_limit) begin
        chain <= '0;
      end else begin
        age <= age + AW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || link_fail || !data_active) begin
      led_q <= 1'b1;
      tog   <= '0;
    end else if (tog == TW'(TOG_CYC - 1)) begin
      led_q <= ~led_q;
      tog   <= '0;
    end else begin
      tog <= tog + TW'(1);
    end
  end

  assign status_led = led_q & ~link_fail;

  // R2
  age_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    age < AW'(FAIL_CYC));

  // R3
  early_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_fail && lp_strobe && !data_active && age < AW'(MIN_CYC)) |=> (age != '0));

  // R4
  rise_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_fail) |-> (!$past(lp_strobe) && !$past(data_active)));

  // R6
  data_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_fail && data_active) |=> !link_fail);

  // R7
  fail_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(link_fail) |-> ($past(data_active) || $past(lp_strobe)));

  // R9
  led_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_fail && !data_active) |=> (status_led || link_fail));

  // R10
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_fail && data_active) |=> !link_fail);

endmodule

// File: tb/test_link_integrity_mon.sv
module test_link_integrity_mon;
  localparam int MIN_T = 20;
  localparam int FAIL_T = 100;
  localparam int TOG_T = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lp = 1'b0;
  logic dat = 1'b0;
  logic fail_o, led_o;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  link_integrity_mon #(.MIN_CYC(MIN_T), .FAIL_CYC(FAIL_T), .TOG_CYC(TOG_T), .RELINK_PULSES(2))
    i_link_integrity_mon (.clk(clk), .rst_n(rst_n), .lp_strobe(lp), .data_active(dat),
                          .link_fail(fail_o), .status_led(led_o));

  // gap (idle edges), pulse, expected link_fail, expected status_led
  localparam int VEC[9][3] = '{
    '{30, 0, 1},  // R2 window pulse
    '{50, 0, 1},  // R2
    '{5,  0, 1},  // R3 early, age continues (6)
    '{13, 0, 1},  // R3 age 19 still early
    '{0,  0, 1},  // R2 age 20 lower edge
    '{99, 0, 1},  // R2 age 99 upper edge
    '{100, 1, 0}, // R4 fail, pulse starts chain, R5
    '{10, 1, 0},  // R7 early pulse restarts chain
    '{25, 0, 1}   // R7 second in-window pulse relinks
  };

  task automatic tick(input logic l, input logic d);
    lp = l; dat = d;
    @(posedge clk);
    @(negedge clk);
    lp = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 1'b0);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #1600000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk("R1 fail", fail_o, 1'b0);
    chk("R1 led", led_o, 1'b1);
    rst_n = 1'b1;

    for (int v = 0; v < 9; v++) begin
      idle(VEC[v][0]);
      tick(1'b1, 1'b0);
      chk($sformatf("R2/R3/R4/R7 row%0d fail", v), fail_o, VEC[v][1][0]);
      chk($sformatf("R5/R9 row%0d led", v), led_o, VEC[v][2][0]);
    end

    // R4 exact failure edge
    idle(FAIL_T - 1);
    chk("R4 before limit", fail_o, 1'b0);
    idle(1);
    chk("R4 at limit", fail_o, 1'b1);
    chk("R5 led low", led_o, 1'b0);

    // R7 chain dropped on timeout
    tick(1'b1, 1'b0);
    idle(FAIL_T);
    tick(1'b1, 1'b0);
    chk("R7 chain restart", fail_o, 1'b1);
    idle(MIN_T + 4);
    tick(1'b1, 1'b0);
    chk("R7 relink", fail_o, 1'b0);

    // R6 data exits fail, R8 toggle, R10 no fail during data
    idle(FAIL_T);
    chk("R4 fail again", fail_o, 1'b1);
    tick(1'b0, 1'b1);
    chk("R6 data exit", fail_o, 1'b0);
    chk("R8 led start", led_o, 1'b1);
    for (int i = 0; i < TOG_T - 1; i++) tick(1'b0, 1'b1);
    chk("R8 before toggle", led_o, 1'b1);
    tick(1'b0, 1'b1);
    chk("R8 toggle low", led_o, 1'b0);
    for (int i = 0; i < TOG_T; i++) tick(1'b0, 1'b1);
    chk("R8 toggle high", led_o, 1'b1);
    begin
      int bad = 0;
      for (int i = 0; i < 3 * FAIL_T; i++) begin
        tick(1'b0, 1'b1);
        if (fail_o !== 1'b0) bad++;
      end
      chk("R10 no fail in data", bad == 0, 1'b1);
    end
    tick(1'b0, 1'b0);
    chk("R9 led after data", led_o, 1'b1);
    begin
      int low = 0;
      for (int i = 0; i < FAIL_T / 2; i++) begin
        tick(1'b0, 1'b0);
        if (led_o !== 1'b1) low++;
      end
      chk("R9 steady high", low == 0, 1'b1);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule